// File: doc/BRIEF.md
# Bus Interrupt Acknowledge Router

This block sits in a host bridge and services a backplane interrupt scheme with seven request levels. Configuration decides, for each level, whether the bridge claims it. When a claimed level is pending, the block runs an acknowledge cycle. It presents the level code and waits for the interrupter to strobe back an 8-bit vector. It then forwards a one-cycle interrupt pulse to the host CPU target assigned to that level.

Levels that are not claimed are never acknowledged here, so another handler on the same bus can service them. The routing table spans seven levels but may reference at most six distinct CPU targets. A route write that would break this limit is refused and flagged. An acknowledge cycle that receives no strobe within a programmable window is abandoned with an error flag.

Top module: `irq_ack_router`

## Requirements
- R1: After reset every output is zero, no level is claimed, and every level routes to target 0.
- R2: Request bit i of `irq_req` is level i+1. `iack_level` carries the binary code (1 to 7) of the level under acknowledge while `iack_active` is high, holds that code for the whole cycle, and reads 0 while idle.
- R3: A pending level that is not claimed is never acknowledged and is left pending.
- R4: When several claimed levels are pending, the highest-numbered one is acknowledged first.
- R5: `iack_active` rises one clock after a claimed pending level is seen. A `dtack` high while active captures `vec_in`. One clock later, `vec_data` and `vec_level` hold the vector and level, `vec_valid` is 1 and stays 1, and `iack_active` is low.
- R6: In the same clock as the R5 capture update, bit t of `cpu_irq` pulses for exactly one cycle, where t is the target routed for the captured level. No other bit pulses.
- R7: Across all seven levels, the route entries name at most MAX_DISTINCT (default 6) distinct targets. A write with `cfg_route_we` that would exceed this is refused. `cfg_reject` pulses one clock later, and neither the claim nor the route of that level changes.
- R8: When `dtack` stays low for tmo_limit+1 active cycles, `ack_err` pulses with `err_level` holding the level. `iack_active` drops, no `cpu_irq` bit pulses, and the vector register keeps its old value. A strobe in the last allowed cycle is still accepted.
- R9: A write with `cfg_lvl` equal to 0 changes no claim and no route, and is not refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Pending request per level, bit i = level i+1 |
| cfg_claim_we | input | 1 | Write the claim bit of `cfg_lvl` |
| cfg_route_we | input | 1 | Write the route target of `cfg_lvl` |
| cfg_lvl | input | 3 | Level addressed by a configuration write |
| cfg_claim | input | 1 | Claim value to write |
| cfg_tgt | input | TGT_W (3) | Target value to write |
| cfg_reject | output | 1 | Pulse: last route write refused |
| tmo_limit | input | TMO_W (12) | Acknowledge timeout limit |
| iack_active | output | 1 | Acknowledge cycle in progress |
| iack_level | output | 3 | Level code being acknowledged |
| dtack | input | 1 | Data-acknowledge strobe from the interrupter |
| vec_in | input | 8 | Vector returned by the interrupter |
| cpu_irq | output | N_TGT (8) | One-cycle interrupt pulse per target |
| vec_valid | output | 1 | A vector has been captured since reset |
| vec_data | output | 8 | Last captured vector |
| vec_level | output | 3 | Level of the last captured vector |
| ack_err | output | 1 | Pulse: acknowledge timed out |
| err_level | output | 3 | Level of the last timed-out acknowledge |

## Verification
The strobe and the timeout can meet in one cycle: when `dtack` arrives exactly in the cycle where the wait counter reaches `tmo_limit`, both capture and abort are candidates. The bench holds back the strobe for exactly tmo_limit further cycles after `iack_active` appears, then expects a normal capture and routed pulse with `ack_err` low. A separate case withholds the strobe one cycle longer and expects the error pulse instead. Random delays across the whole window cover the cycles in between.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int N_LVL = 7;
    localparam int LVL_W = 3;
    localparam int VEC_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [N_LVL-1:0] lvl_mask_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ACK  = 2'd1
    } seq_state_e;

    typedef struct packed {
        lvl_t lvl;
        vec_t vec;
    } capture_t;

    // highest set bit of a level mask as a level code, 0 when empty
    function automatic lvl_t top_level(input lvl_mask_t m);
        lvl_t r;
        r = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (m[i]) r = lvl_t'(i + 1);
        end
        return r;
    endfunction

    // one-hot mask for a level code, empty for code 0
    function automatic lvl_mask_t level_bit(input lvl_t l);
        lvl_mask_t r;
        r = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (int'(l) == i + 1) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_ack_pkg::*;
#(
    parameter int N_TGT        = 8,
    parameter int MAX_DISTINCT = 6,
    localparam int TGT_W       = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             claim_we,
    input  logic             route_we,
    input  lvl_t             wr_lvl,
    input  logic             wr_claim,
    input  logic [TGT_W-1:0] wr_tgt,
    output logic             wr_reject,
    output lvl_mask_t        claim_mask,
    input  lvl_t             rd_lvl,
    output logic [TGT_W-1:0] rd_tgt,
    output logic [N_TGT-1:0] used_mask
);

    logic [TGT_W-1:0] tgt_q  [N_LVL];
    logic [TGT_W-1:0] tgt_nx [N_LVL];
    logic             claim_q[N_LVL];
    logic [N_TGT-1:0] used_nx;
    lvl_mask_t        hit;
    lvl_mask_t        rd_hit;
    int               n_nx;
    logic             over;
    logic             do_wr;
    logic             commit;

    // candidate table and its distinct-target count
    always_comb begin
        hit     = level_bit(wr_lvl);
        used_nx = '0;
        n_nx    = 0;
        for (int i = 0; i < N_LVL; i++) begin
            tgt_nx[i] = (route_we && hit[i]) ? wr_tgt : tgt_q[i];
            used_nx[tgt_nx[i]] = 1'b1;
        end
        for (int t = 0; t < N_TGT; t++) begin
            if (used_nx[t]) n_nx = n_nx + 1;
        end
        over   = route_we && (n_nx > MAX_DISTINCT);
        do_wr  = (claim_we || route_we) && (|hit);
        commit = do_wr && !over;
    end

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                tgt_q[g]   <= '0;
                claim_q[g] <= 1'b0;
            end else if (commit && hit[g]) begin
                if (route_we) tgt_q[g]   <= wr_tgt;
                if (claim_we) claim_q[g] <= wr_claim;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_reject <= 1'b0;
        else     wr_reject <= do_wr && over;
    end

    always_comb begin
        rd_hit    = level_bit(rd_lvl);
        rd_tgt    = '0;
        used_mask = '0;
        for (int i = 0; i < N_LVL; i++) begin
            claim_mask[i] = claim_q[i];
            used_mask[tgt_q[i]] = 1'b1;
            if (rd_hit[i]) rd_tgt = tgt_q[i];
        end
    end

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_ack_pkg::*;
(
    input  lvl_mask_t req,
    input  lvl_mask_t claim,
    output logic      pick_valid,
    output lvl_t      pick_lvl
);

    lvl_mask_t live;

    assign live       = req & claim;
    assign pick_valid = |live;
    assign pick_lvl   = top_level(live);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int N_TGT  = 8,
    parameter int TMO_W  = 12,
    localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_valid,
    input  lvl_t             pick_lvl,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             dtack,
    input  vec_t             vec_in,
    input  logic [TGT_W-1:0] route_tgt,
    output logic             iack_active,
    output lvl_t             iack_level,
    output logic [N_TGT-1:0] cpu_irq,
    output capture_t         capt,
    output logic             capt_valid,
    output logic             ack_err,
    output lvl_t             err_level
);

    seq_state_e       state;
    lvl_t             cur_lvl;
    logic [TMO_W-1:0] cnt;
    logic [N_TGT-1:0] tgt_onehot;

    assign tgt_onehot  = N_TGT'(1) << route_tgt;
    assign iack_active = (state == SQ_ACK);
    assign iack_level  = (state == SQ_ACK) ? cur_lvl : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            cur_lvl    <= '0;
            cnt        <= '0;
            cpu_irq    <= '0;
            capt       <= '0;
            capt_valid <= 1'b0;
            ack_err    <= 1'b0;
            err_level  <= '0;
        end else begin
            cpu_irq <= '0;
            ack_err <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (pick_valid) begin
                        state   <= SQ_ACK;
                        cur_lvl <= pick_lvl;
                        cnt     <= '0;
                    end
                end
                SQ_ACK: begin
                    if (dtack) begin
                        capt.lvl   <= cur_lvl;
                        capt.vec   <= vec_in;
                        capt_valid <= 1'b1;
                        cpu_irq    <= tgt_onehot;
                        state      <= SQ_IDLE;
                    end else if (cnt == tmo_limit) begin
                        ack_err   <= 1'b1;
                        err_level <= cur_lvl;
                        state     <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + TMO_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_ack_router.sv
module irq_ack_router
    import irq_ack_pkg::*;
#(
    parameter int N_TGT        = 8,
    parameter int MAX_DISTINCT = 6,
    parameter int TMO_W        = 12,
    localparam int TGT_W       = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_LVL-1:0] irq_req,
    input  logic             cfg_claim_we,
    input  logic             cfg_route_we,
    input  logic [LVL_W-1:0] cfg_lvl,
    input  logic             cfg_claim,
    input  logic [TGT_W-1:0] cfg_tgt,
    output logic             cfg_reject,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             iack_active,
    output logic [LVL_W-1:0] iack_level,
    input  logic             dtack,
    input  logic [VEC_W-1:0] vec_in,
    output logic [N_TGT-1:0] cpu_irq,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_data,
    output logic [LVL_W-1:0] vec_level,
    output logic             ack_err,
    output logic [LVL_W-1:0] err_level
);

    lvl_mask_t        claim_mask;
    logic [N_TGT-1:0] used_mask;
    logic [TGT_W-1:0] route_tgt;
    logic             pick_valid;
    lvl_t             pick_lvl;
    capture_t         capt;

    irq_route_table #(
        .N_TGT       (N_TGT),
        .MAX_DISTINCT(MAX_DISTINCT)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .claim_we  (cfg_claim_we),
        .route_we  (cfg_route_we),
        .wr_lvl    (cfg_lvl),
        .wr_claim  (cfg_claim),
        .wr_tgt    (cfg_tgt),
        .wr_reject (cfg_reject),
        .claim_mask(claim_mask),
        .rd_lvl    (iack_level),
        .rd_tgt    (route_tgt),
        .used_mask (used_mask)
    );

    irq_level_pick u_pick (
        .req       (irq_req),
        .claim     (claim_mask),
        .pick_valid(pick_valid),
        .pick_lvl  (pick_lvl)
    );

    irq_ack_seq #(
        .N_TGT(N_TGT),
        .TMO_W(TMO_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pick_valid (pick_valid),
        .pick_lvl   (pick_lvl),
        .tmo_limit  (tmo_limit),
        .dtack      (dtack),
        .vec_in     (vec_in),
        .route_tgt  (route_tgt),
        .iack_active(iack_active),
        .iack_level (iack_level),
        .cpu_irq    (cpu_irq),
        .capt       (capt),
        .capt_valid (vec_valid),
        .ack_err    (ack_err),
        .err_level  (err_level)
    );

    assign vec_data  = capt.vec;
    assign vec_level = capt.lvl;

endmodule

// File: rtl/irq_ack_router_chk.sv
module irq_ack_router_chk
    import irq_ack_pkg::*;
#(
    parameter int N_TGT        = 8,
    parameter int MAX_DISTINCT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [N_LVL-1:0] irq_req,
    input logic [N_LVL-1:0] claim_mask,
    input logic [N_TGT-1:0] used_mask,
    input logic             cfg_reject,
    input logic             iack_active,
    input logic [LVL_W-1:0] iack_level,
    input logic             dtack,
    input logic [N_TGT-1:0] cpu_irq,
    input logic             vec_valid,
    input logic             ack_err
);

    a_r2_level_coded: assert property (@(posedge clk) disable iff (rst)
        iack_active |-> iack_level != '0);

    a_r2_level_held: assert property (@(posedge clk) disable iff (rst)
        (iack_active && $past(iack_active)) |-> $stable(iack_level));

    a_r3_claimed_only: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_active) |-> |($past(claim_mask & irq_req) & level_bit(iack_level)));

    a_r4_highest_first: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_active) |-> (($past(claim_mask & irq_req) >> iack_level) == '0));

    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cpu_irq));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|cpu_irq) |=> (cpu_irq == '0));

    a_r5_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (|cpu_irq) |-> ($past(iack_active && dtack) && vec_valid && !iack_active));

    a_r8_timeout_clean: assert property (@(posedge clk) disable iff (rst)
        ack_err |-> ($past(iack_active) && !$past(dtack) && cpu_irq == '0 && !iack_active));

    a_r7_distinct_limit: assert property (@(posedge clk) disable iff (rst)
        $countones(used_mask) <= MAX_DISTINCT);

    a_r7_reject_frozen: assert property (@(posedge clk) disable iff (rst)
        cfg_reject |-> ($stable(used_mask) && $stable(claim_mask)));

endmodule

bind irq_ack_router irq_ack_router_chk #(
    .N_TGT       (N_TGT),
    .MAX_DISTINCT(MAX_DISTINCT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .claim_mask (claim_mask),
    .used_mask  (used_mask),
    .cfg_reject (cfg_reject),
    .iack_active(iack_active),
    .iack_level (iack_level),
    .dtack      (dtack),
    .cpu_irq    (cpu_irq),
    .vec_valid  (vec_valid),
    .ack_err    (ack_err)
);

// File: tb/sim_irq_ack_router.sv
`timescale 1ns/1ps
module sim_irq_ack_router;
    import irq_ack_pkg::*;

    localparam int N_TGT = 8;
    localparam int TGT_W = 3;
    localparam int MAXD  = 6;
    localparam int TMO_W = 12;
    localparam int TMO   = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [6:0]       irq_req = '0;
    logic             cfg_claim_we = 1'b0;
    logic             cfg_route_we = 1'b0;
    logic [2:0]       cfg_lvl = '0;
    logic             cfg_claim = 1'b0;
    logic [TGT_W-1:0] cfg_tgt = '0;
    logic             cfg_reject;
    logic [TMO_W-1:0] tmo_limit = TMO_W'(TMO);
    logic             iack_active;
    logic [2:0]       iack_level;
    logic             dtack = 1'b0;
    logic [7:0]       vec_in = '0;
    logic [N_TGT-1:0] cpu_irq;
    logic             vec_valid;
    logic [7:0]       vec_data;
    logic [2:0]       vec_level;
    logic             ack_err;
    logic [2:0]       err_level;

    irq_ack_router #(.N_TGT(N_TGT), .MAX_DISTINCT(MAXD), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .cfg_claim_we(cfg_claim_we), .cfg_route_we(cfg_route_we),
        .cfg_lvl(cfg_lvl), .cfg_claim(cfg_claim), .cfg_tgt(cfg_tgt),
        .cfg_reject(cfg_reject), .tmo_limit(tmo_limit),
        .iack_active(iack_active), .iack_level(iack_level),
        .dtack(dtack), .vec_in(vec_in), .cpu_irq(cpu_irq),
        .vec_valid(vec_valid), .vec_data(vec_data), .vec_level(vec_level),
        .ack_err(ack_err), .err_level(err_level)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit m_claim[7];
    int m_tgt[7];
    int last_vec = 0;
    int last_lvl = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int distinct_after(input int lvl, input bit rw, input int tgt);
        bit [N_TGT-1:0] u;
        u = '0;
        for (int i = 0; i < 7; i++) u[(rw && i == lvl - 1) ? tgt : m_tgt[i]] = 1'b1;
        return $countones(u);
    endfunction

    function automatic int pick(input logic [6:0] r);
        int p;
        p = 0;
        for (int i = 0; i < 7; i++) if (r[i] && m_claim[i]) p = i + 1;
        return p;
    endfunction

    task automatic cfg_write(input int lvl, input bit cw, input bit c, input bit rw, input int t);
        bit exp_rej;
        cfg_lvl = 3'(lvl); cfg_claim_we = cw; cfg_claim = c;
        cfg_route_we = rw; cfg_tgt = TGT_W'(t);
        @(negedge clk);
        cfg_claim_we = 1'b0; cfg_route_we = 1'b0;
        exp_rej = (lvl != 0) && rw && (distinct_after(lvl, 1'b1, t) > MAXD);
        if (lvl == 0) check(cfg_reject === 1'b0, "R9 level 0 write not refused", int'(cfg_reject), 0);
        else          check(cfg_reject === exp_rej, "R7 reject flag", int'(cfg_reject), int'(exp_rej));
        if (lvl != 0 && !exp_rej) begin
            if (cw) m_claim[lvl-1] = c;
            if (rw) m_tgt[lvl-1]   = t;
        end
    endtask

    // called at a negedge where the next edge picks the highest claimed level
    task automatic serve(input bit tmo_case, input int delay);
        int lvl;
        int v;
        lvl = pick(irq_req);
        @(negedge clk);
        check(iack_active === 1'b1 && int'(iack_level) == lvl, "R4 level acknowledged", int'(iack_level), lvl);
        if (tmo_case) begin
            repeat (TMO) @(negedge clk);
            check(iack_active === 1'b1 && ack_err === 1'b0, "R8 still waiting", int'(ack_err), 0);
            @(negedge clk);
            check(ack_err === 1'b1 && int'(err_level) == lvl, "R8 timeout level", int'(err_level), lvl);
            check(cpu_irq == '0 && iack_active === 1'b0, "R8 nothing forwarded", int'(cpu_irq), 0);
            check(int'(vec_data) == last_vec && int'(vec_level) == last_lvl, "R8 vector kept", int'(vec_data), last_vec);
            irq_req[lvl-1] = 1'b0;
        end else begin
            repeat (delay) @(negedge clk);
            v = int'($urandom_range(255));
            dtack = 1'b1; vec_in = 8'(v); irq_req[lvl-1] = 1'b0;
            @(negedge clk);
            dtack = 1'b0;
            if (delay == TMO)
                check(ack_err === 1'b0, "R8 late strobe accepted", int'(ack_err), 0);
            check(cpu_irq == N_TGT'(1) << m_tgt[lvl-1], "R6 routed pulse", int'(cpu_irq), 1 << m_tgt[lvl-1]);
            check(int'(vec_data) == v && int'(vec_level) == lvl && vec_valid === 1'b1, "R5 vector capture", int'(vec_data), v);
            check(iack_active === 1'b0, "R5 cycle ends", int'(iack_active), 0);
            last_vec = v; last_lvl = lvl;
        end
    endtask

    task automatic run_all(input int tmo_pct);
        while (pick(irq_req) != 0) begin
            int d;
            d = int'($urandom_range(TMO));
            serve(($urandom_range(99) < tmo_pct), d);
        end
        repeat (3) begin
            @(negedge clk);
            check(iack_active === 1'b0, "R3 unclaimed left alone", int'(iack_active), 0);
        end
        irq_req = '0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) begin m_claim[i] = 1'b0; m_tgt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(iack_active === 1'b0 && iack_level == '0, "R1 idle after reset", int'(iack_active), 0);
        check(cpu_irq == '0 && ack_err === 1'b0 && cfg_reject === 1'b0, "R1 no pulses", int'(cpu_irq), 0);
        check(vec_valid === 1'b0 && vec_data == '0 && vec_level == '0, "R1 vector clear", int'(vec_data), 0);

        // R3: nothing claimed, everything pending
        irq_req = 7'h7F;
        run_all(0);

        // R1 default route: claim level 3 only
        cfg_write(3, 1'b1, 1'b1, 1'b0, 0);
        irq_req[2] = 1'b1;
        serve(1'b0, 1);
        @(negedge clk);
        check(cpu_irq == '0, "R6 pulse lasts one cycle", int'(cpu_irq), 0);
        check(m_tgt[2] == 0, "R1 default target", m_tgt[2], 0);

        // R9: level 0 write does nothing
        cfg_write(0, 1'b1, 1'b1, 1'b1, 7);
        irq_req = 7'b0001000;
        run_all(0);

        // R7 distinct limit, directed
        for (int l = 1; l <= 7; l++) cfg_write(l, 1'b1, 1'b1, 1'b0, 0);
        for (int l = 1; l <= 5; l++) cfg_write(l, 1'b0, 1'b0, 1'b1, l);
        cfg_write(6, 1'b0, 1'b0, 1'b1, 6);
        cfg_write(6, 1'b1, 1'b0, 1'b1, 7);
        cfg_write(6, 1'b0, 1'b0, 1'b1, 5);
        cfg_write(7, 1'b0, 1'b0, 1'b1, 6);
        irq_req = 7'h7F;
        run_all(0);

        // R8 corners: strobe in last allowed cycle, then a timeout
        irq_req[6] = 1'b1;
        serve(1'b0, TMO);
        irq_req[1] = 1'b1;
        serve(1'b1, 0);
        @(negedge clk);

        // R2 random mix
        for (int r = 0; r < 60; r++) begin
            int nw;
            nw = int'($urandom_range(3));
            for (int k = 0; k < nw; k++)
                cfg_write(int'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(3) != 0),
                          1'($urandom_range(1)), int'($urandom_range(N_TGT - 1)));
            irq_req = 7'($urandom_range(127));
            run_all(15);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule